// File: doc/BRIEF.md
# Partitioned Free-List Register Renamer

This block renames a group of up to four instructions per cycle for an out-of-order core whose physical register file is split into four disjoint subsets, one per execution cluster. Each instruction arrives already steered: a two-bit subset tag names the subset that must receive its result. Each subset keeps its own free list. The block counts how many destinations each subset needs in the group, takes exactly that many registers from each list, and merges them back into group order. It also resolves read-after-write and write-after-write dependencies inside the group and updates the logical-to-physical map table.

The work is split across two registered stages. The first stage latches the group and its per-subset demand counts. The second stage checks that every list can cover its demand. It then pops the lists, merges the registers, reads and writes the map table, and loads the output register. Groups enter through a valid/ready handshake. A group is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low whenever the first stage holds a group that cannot move on, either because a list is short or because the output register is full and `out_ready` is low. A result sits at the output until it is taken on an edge where `out_valid` and `out_ready` are both high. Released registers come back through a plain commit port with one lane per subset.

A physical register index is 9 bits wide. The upper two bits are the subset number and the lower seven bits are the local index inside the subset (0 to 87).

Top module: `partitioned_renamer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Logical register r maps to subset r mod 4 with local index r/4. Each free list holds local indices 8 to 87 in ascending order.
- R2: For an enabled slot, the destination's upper two bits equal the slot's tag. Its local index is the next entry of that subset's list, and earlier slots in the group with the same tag take earlier entries.
- R3: Each list gives up exactly as many registers as there are enabled slots tagged with its subset. A slot with `in_dst_en` at 0 takes no register, and its `out_pdst` and `out_pold` read 0.
- R4: A source that names a logical register written by an earlier enabled slot of the same group receives the latest such slot's new register. Otherwise it receives the map-table entry.
- R5: `out_pold` of an enabled slot is the mapping its destination held just before that slot: an earlier in-group writer's new register if one exists, else the map entry.
- R6: After a group is renamed, each logical register it wrote maps to the register of its last writer in the group, as seen by the sources of later groups.
- R7: If any list holds fewer registers than the group needs from it, the group waits in the first stage. No list is popped, `out_valid` does not rise, and `in_ready` stays 0 until every list can cover its demand.
- R8: A register released on lane i (`rel_valid[i]` high, `rel_preg` upper bits equal to i) is appended to the tail of list i and handed out after all entries already in it.
- R9: While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values. If the first stage is also full, `in_ready` is 0.
- R10: A group taken on a rising edge appears at the output after the next rising edge, provided the lists suffice and the output register is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Rename group offered |
| in_ready | output | 1 | Group accepted this edge if valid |
| in_dst_en | input | 4 | Per-slot destination present |
| in_dst | input | 20 | Per-slot logical destination, 5 bits each, slot 0 lowest |
| in_src0 | input | 20 | Per-slot first logical source |
| in_src1 | input | 20 | Per-slot second logical source |
| in_tag | input | 8 | Per-slot subset tag, 2 bits each |
| out_valid | output | 1 | Renamed group available |
| out_ready | input | 1 | Consumer takes the renamed group |
| out_dst_en | output | 4 | Per-slot destination present |
| out_pdst | output | 36 | Per-slot new physical destination, 9 bits each |
| out_psrc0 | output | 36 | Per-slot physical first source |
| out_psrc1 | output | 36 | Per-slot physical second source |
| out_pold | output | 36 | Per-slot previous mapping of the destination |
| rel_valid | input | 4 | Per-subset release strobe |
| rel_preg | input | 36 | Per-subset released physical register, 9 bits each |

## Verification
Several properties are checked on every cycle:
- No list is ever popped past its count or pushed past its depth.
- A held output stays stable.
- A short list keeps `out_valid` from rising.
- Every new destination lands in the subset its tag asked for.
- Every release lane carries its own subset.

The bench scenarios cover what needs a reference model of the lists and the map:
- the exact register handed to each slot;
- in-group forwarding to sources and old mappings;
- the final map seen by a later group;
- ordering of released registers behind the existing entries;
- the all-or-nothing stall when one subset runs dry.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int SUBSETS = 4;
  localparam int SUB_W   = 2;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int DEPTH     = 88,
  parameter int INIT_BASE = 8,
  parameter int INIT_CNT  = 80,
  parameter int LOC_W     = 7,
  parameter int GROUP     = 4,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int PN_W     = $clog2(GROUP + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            push,
  input  logic [LOC_W-1:0]                push_loc,
  input  logic [PN_W-1:0]                 pop_n,
  output logic [CW-1:0]                   avail,
  output logic [GROUP-1:0][LOC_W-1:0]     head_loc
);
  logic [LOC_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] head, tail;
  logic [CW-1:0]    count;

  function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W:0] v);
    if (v >= (PTR_W+1)'(DEPTH)) return PTR_W'(v - (PTR_W+1)'(DEPTH));
    return PTR_W'(v);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++)
        mem[k] <= (k < INIT_CNT) ? LOC_W'(INIT_BASE + k) : '0;
      head  <= '0;
      tail  <= wrap((PTR_W+1)'(INIT_CNT % DEPTH));
      count <= CW'(INIT_CNT);
    end else begin
      if (push) begin
        mem[tail] <= push_loc;
        tail      <= wrap({1'b0, tail} + 1'b1);
      end
      head  <= wrap({1'b0, head} + (PTR_W+1)'(pop_n));
      count <= count + CW'(push) - CW'(pop_n);
    end
  end

  always_comb begin
    for (int k = 0; k < GROUP; k++)
      head_loc[k] = mem[wrap({1'b0, head} + (PTR_W+1)'(k))];
  end

  assign avail = count;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= count);  // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((count + CW'(1)) - CW'(pop_n)) <= CW'(DEPTH));  // R8
endmodule

// File: rtl/rn_group_merge.sv
module rn_group_merge
  import rn_pkg::*;
#(
  parameter int GROUP     = 4,
  parameter int ARCH_REGS = 32,
  parameter int LOC_W     = 7,
  localparam int LREG_W   = $clog2(ARCH_REGS),
  localparam int PREG_W   = SUB_W + LOC_W,
  localparam int RK_W     = $clog2(GROUP)
) (
  input  logic [GROUP-1:0]                           dst_en,
  input  logic [GROUP-1:0][LREG_W-1:0]               dst,
  input  logic [GROUP-1:0][LREG_W-1:0]               src0,
  input  logic [GROUP-1:0][LREG_W-1:0]               src1,
  input  logic [GROUP-1:0][SUB_W-1:0]                tag,
  input  logic [SUBSETS-1:0][GROUP-1:0][LOC_W-1:0]   heads,
  input  logic [ARCH_REGS-1:0][PREG_W-1:0]           map_q,
  output logic [GROUP-1:0][PREG_W-1:0]               pdst,
  output logic [GROUP-1:0][PREG_W-1:0]               psrc0,
  output logic [GROUP-1:0][PREG_W-1:0]               psrc1,
  output logic [GROUP-1:0][PREG_W-1:0]               pold,
  output logic [ARCH_REGS-1:0][PREG_W-1:0]           map_d
);
  // Expand: each enabled slot takes the entry of its subset list at its rank.
  always_comb begin
    for (int j = 0; j < GROUP; j++) begin
      logic [RK_W-1:0] rk;
      rk = '0;
      for (int k = 0; k < j; k++)
        if (dst_en[k] && tag[k] == tag[j]) rk = rk + 1'b1;
      pdst[j] = dst_en[j] ? {tag[j], heads[tag[j]][rk]} : '0;
    end
  end

  // Forward in-group writers to sources and old mappings; last writer updates map.
  always_comb begin
    map_d = map_q;
    for (int j = 0; j < GROUP; j++) begin
      psrc0[j] = map_q[src0[j]];
      psrc1[j] = map_q[src1[j]];
      pold[j]  = map_q[dst[j]];
      for (int k = 0; k < j; k++) begin
        if (dst_en[k] && dst[k] == src0[j]) psrc0[j] = pdst[k];
        if (dst_en[k] && dst[k] == src1[j]) psrc1[j] = pdst[k];
        if (dst_en[k] && dst[k] == dst[j])  pold[j]  = pdst[k];
      end
      if (!dst_en[j]) pold[j] = '0;
      if (dst_en[j]) map_d[dst[j]] = pdst[j];
    end
  end
endmodule

// File: rtl/partitioned_renamer.sv
module partitioned_renamer
  import rn_pkg::*;
#(
  parameter int GROUP     = 4,
  parameter int ARCH_REGS = 32,
  parameter int SUB_REGS  = 88,
  localparam int LREG_W   = $clog2(ARCH_REGS),
  localparam int LOC_W    = $clog2(SUB_REGS),
  localparam int PREG_W   = SUB_W + LOC_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [GROUP-1:0]           in_dst_en,
  input  logic [GROUP*LREG_W-1:0]    in_dst,
  input  logic [GROUP*LREG_W-1:0]    in_src0,
  input  logic [GROUP*LREG_W-1:0]    in_src1,
  input  logic [GROUP*SUB_W-1:0]     in_tag,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [GROUP-1:0]           out_dst_en,
  output logic [GROUP*PREG_W-1:0]    out_pdst,
  output logic [GROUP*PREG_W-1:0]    out_psrc0,
  output logic [GROUP*PREG_W-1:0]    out_psrc1,
  output logic [GROUP*PREG_W-1:0]    out_pold,
  input  logic [SUBSETS-1:0]         rel_valid,
  input  logic [SUBSETS*PREG_W-1:0]  rel_preg
);
  localparam int ARCH_PER  = ARCH_REGS / SUBSETS;
  localparam int FREE_INIT = SUB_REGS - ARCH_PER;
  localparam int CNT_W     = $clog2(GROUP + 1);
  localparam int FL_CW     = $clog2(SUB_REGS + 1);

  // Stage 1: latched group and per-subset demand
  logic                             s1_valid;
  logic [GROUP-1:0]                 s1_dst_en;
  logic [GROUP-1:0][LREG_W-1:0]     s1_dst, s1_src0, s1_src1;
  logic [GROUP-1:0][SUB_W-1:0]      s1_tag;
  logic [SUBSETS-1:0][CNT_W-1:0]    s1_need, need_in;
  logic [GROUP-1:0][SUB_W-1:0]      in_tag_a;

  logic [SUBSETS-1:0][FL_CW-1:0]            fl_avail;
  logic [SUBSETS-1:0][CNT_W-1:0]            fl_pop;
  logic [SUBSETS-1:0][GROUP-1:0][LOC_W-1:0] fl_heads;
  logic [ARCH_REGS-1:0][PREG_W-1:0]         map_q, map_d;
  logic [GROUP-1:0][PREG_W-1:0]             m_pdst, m_psrc0, m_psrc1, m_pold;

  logic lists_ok, out_free, s1_adv;

  assign in_tag_a = in_tag;

  always_comb begin
    for (int i = 0; i < SUBSETS; i++) begin
      need_in[i] = '0;
      for (int j = 0; j < GROUP; j++)
        if (in_dst_en[j] && in_tag_a[j] == SUB_W'(i)) need_in[i] = need_in[i] + 1'b1;
    end
  end

  always_comb begin
    lists_ok = 1'b1;
    for (int i = 0; i < SUBSETS; i++)
      if (fl_avail[i] < FL_CW'(s1_need[i])) lists_ok = 1'b0;
  end

  assign out_free = !out_valid || out_ready;
  assign s1_adv   = s1_valid && lists_ok && out_free;
  assign in_ready = !s1_valid || s1_adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_dst_en <= '0;
      s1_dst    <= '0;
      s1_src0   <= '0;
      s1_src1   <= '0;
      s1_tag    <= '0;
      s1_need   <= '0;
    end else if (in_ready) begin
      s1_valid  <= in_valid;
      s1_dst_en <= in_dst_en;
      s1_dst    <= in_dst;
      s1_src0   <= in_src0;
      s1_src1   <= in_src1;
      s1_tag    <= in_tag;
      s1_need   <= need_in;
    end
  end

  // Per-subset free lists
  for (genvar i = 0; i < SUBSETS; i++) begin : g_list
    logic lane_push;
    assign lane_push = rel_valid[i] && rel_preg[i*PREG_W + LOC_W +: SUB_W] == SUB_W'(i);
    assign fl_pop[i] = s1_adv ? s1_need[i] : '0;

    rn_free_list #(
      .DEPTH(SUB_REGS), .INIT_BASE(ARCH_PER), .INIT_CNT(FREE_INIT),
      .LOC_W(LOC_W), .GROUP(GROUP)
    ) u_list (
      .clk(clk), .rst_n(rst_n),
      .push(lane_push), .push_loc(rel_preg[i*PREG_W +: LOC_W]),
      .pop_n(fl_pop[i]), .avail(fl_avail[i]), .head_loc(fl_heads[i])
    );

    AST_REL_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid[i] |-> rel_preg[i*PREG_W + LOC_W +: SUB_W] == SUB_W'(i));  // R8
  end

  rn_group_merge #(.GROUP(GROUP), .ARCH_REGS(ARCH_REGS), .LOC_W(LOC_W)) u_merge (
    .dst_en(s1_dst_en), .dst(s1_dst), .src0(s1_src0), .src1(s1_src1), .tag(s1_tag),
    .heads(fl_heads), .map_q(map_q),
    .pdst(m_pdst), .psrc0(m_psrc0), .psrc1(m_psrc1), .pold(m_pold), .map_d(map_d)
  );

  // Stage 2: map table and output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ARCH_REGS; r++)
        map_q[r] <= {SUB_W'(r % SUBSETS), LOC_W'(r / SUBSETS)};
      out_valid  <= 1'b0;
      out_dst_en <= '0;
      out_pdst   <= '0;
      out_psrc0  <= '0;
      out_psrc1  <= '0;
      out_pold   <= '0;
    end else begin
      if (s1_adv) begin
        map_q      <= map_d;
        out_valid  <= 1'b1;
        out_dst_en <= s1_dst_en;
        out_pdst   <= m_pdst;
        out_psrc0  <= m_psrc0;
        out_psrc1  <= m_psrc1;
        out_pold   <= m_pold;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pdst) && $stable(out_psrc0)
      && $stable(out_psrc1) && $stable(out_pold) && $stable(out_dst_en));  // R9
  AST_STALL_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !lists_ok && !out_valid |=> !out_valid);  // R7

  for (genvar j = 0; j < GROUP; j++) begin : g_chk
    AST_PDST_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      s1_adv && s1_dst_en[j] |=> out_pdst[j*PREG_W + LOC_W +: SUB_W] == $past(s1_tag[j]));  // R2
  end
endmodule

// File: tb/tb_partitioned_renamer.sv
module tb_partitioned_renamer;
  localparam int CLK_PERIOD = 10;
  localparam int G  = 4;
  localparam int PW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [G-1:0] in_dst_en = '0;
  logic [G*5-1:0] in_dst = '0, in_src0 = '0, in_src1 = '0;
  logic [G*2-1:0] in_tag = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [G-1:0] out_dst_en;
  logic [G*PW-1:0] out_pdst, out_psrc0, out_psrc1, out_pold;
  logic [3:0] rel_valid = '0;
  logic [4*PW-1:0] rel_preg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  partitioned_renamer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst_en(in_dst_en), .in_dst(in_dst), .in_src0(in_src0), .in_src1(in_src1),
    .in_tag(in_tag), .out_valid(out_valid), .out_ready(out_ready),
    .out_dst_en(out_dst_en), .out_pdst(out_pdst), .out_psrc0(out_psrc0),
    .out_psrc1(out_psrc1), .out_pold(out_pold), .rel_valid(rel_valid), .rel_preg(rel_preg)
  );

  int checks = 0;
  int errs = 0;

  // Reference model
  int fmem [4][0:255];
  int fhead [4];
  int ftail [4];
  int mmap [32];
  int g_en [4], g_dst [4], g_s0 [4], g_s1 [4], g_tag [4];
  int e_en [2][4], e_pd [2][4], e_s0 [2][4], e_s1 [2][4], e_po [2][4];
  int e_wr = 0, e_rd = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_init();
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 80; k++) fmem[s][k] = 8 + k;
      fhead[s] = 0;
      ftail[s] = 80;
    end
    for (int r = 0; r < 32; r++) mmap[r] = (r % 4) * 128 + r / 4;
  endtask

  task automatic model_group();
    for (int j = 0; j < G; j++) begin
      e_en[e_wr][j] = g_en[j];
      e_s0[e_wr][j] = mmap[g_s0[j]];
      e_s1[e_wr][j] = mmap[g_s1[j]];
      e_pd[e_wr][j] = 0;
      e_po[e_wr][j] = 0;
      if (g_en[j] != 0) begin
        e_po[e_wr][j] = mmap[g_dst[j]];
        e_pd[e_wr][j] = g_tag[j] * 128 + fmem[g_tag[j]][fhead[g_tag[j]]];
        fhead[g_tag[j]]++;
        mmap[g_dst[j]] = e_pd[e_wr][j];
      end
    end
    e_wr = 1 - e_wr;
  endtask

  task automatic set_slot(int j, int en, int dst, int s0, int s1, int tag);
    g_en[j] = en; g_dst[j] = dst; g_s0[j] = s0; g_s1[j] = s1; g_tag[j] = tag;
  endtask

  task automatic push_group();
    @(negedge clk);
    for (int j = 0; j < G; j++) begin
      in_dst_en[j]     = (g_en[j] != 0);
      in_dst[j*5 +: 5] = 5'(g_dst[j]);
      in_src0[j*5 +: 5] = 5'(g_s0[j]);
      in_src1[j*5 +: 5] = 5'(g_s1[j]);
      in_tag[j*2 +: 2] = 2'(g_tag[j]);
    end
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic receive(string req);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    for (int j = 0; j < G; j++) begin
      check(req, int'(out_dst_en[j]), e_en[e_rd][j]);
      check(req, int'(out_pdst[j*PW +: PW]), e_pd[e_rd][j]);
      check(req, int'(out_psrc0[j*PW +: PW]), e_s0[e_rd][j]);
      check(req, int'(out_psrc1[j*PW +: PW]), e_s1[e_rd][j]);
      check(req, int'(out_pold[j*PW +: PW]), e_po[e_rd][j]);
    end
    e_rd = 1 - e_rd;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 out_valid", int'(out_valid), 0);
  endtask

  // Mixed tags, one idle slot, sources from reset map, two-edge latency
  task automatic t_mixed();
    set_slot(0, 1, 1, 5, 6, 2);
    set_slot(1, 1, 2, 7, 8, 0);
    set_slot(2, 1, 3, 9, 10, 2);
    set_slot(3, 0, 4, 11, 12, 1);
    model_group();
    push_group();
    check("R10 not yet valid", int'(out_valid), 0);
    @(negedge clk);
    check("R10 valid after second edge", int'(out_valid), 1);
    receive("R1 R2 R3");
  endtask

  // In-group forwarding, old mappings, map seen by later group
  task automatic t_dep();
    set_slot(0, 1, 6, 1, 2, 1);
    set_slot(1, 1, 6, 6, 6, 1);
    set_slot(2, 1, 7, 6, 3, 3);
    set_slot(3, 1, 8, 1, 7, 0);
    model_group();
    push_group();
    receive("R4 R5");
    set_slot(0, 0, 0, 6, 7, 0);
    set_slot(1, 0, 0, 8, 1, 0);
    set_slot(2, 0, 0, 2, 3, 0);
    set_slot(3, 0, 0, 6, 8, 0);
    model_group();
    push_group();
    receive("R6");
  endtask

  task automatic t_same();
    for (int j = 0; j < G; j++) set_slot(j, 1, 12 + j, j, 31 - j, 0);
    model_group();
    push_group();
    receive("R2 R3 same subset");
  endtask

  task automatic t_backpressure();
    logic [G*PW-1:0] held;
    out_ready = 1'b0;
    for (int j = 0; j < G; j++) set_slot(j, 1, 20 + j, j, j + 1, j);
    model_group();
    push_group();
    for (int j = 0; j < G; j++) set_slot(j, (j % 2), 24 + j, 20 + j, 21, 3 - j);
    model_group();
    push_group();
    check("R9 in_ready low", int'(in_ready), 0);
    held = out_pdst;
    repeat (3) @(negedge clk);
    check("R9 out_valid held", int'(out_valid), 1);
    check("R9 out_pdst stable", int'(out_pdst == held), 1);
    receive("R9 first");
    receive("R9 second");
  endtask

  task automatic t_stall();
    while (ftail[3] - fhead[3] >= 4) begin
      for (int j = 0; j < G; j++) set_slot(j, 1, j, 4 + j, 9, 3);
      model_group();
      push_group();
      receive("R2 drain");
    end
    while (ftail[3] - fhead[3] > 0) begin
      set_slot(0, 1, 30, 29, 28, 3);
      for (int j = 1; j < G; j++) set_slot(j, 0, 0, 0, 0, 0);
      model_group();
      push_group();
      receive("R2 drain");
    end
    set_slot(0, 1, 10, 3, 4, 0);
    set_slot(1, 1, 11, 10, 5, 3);
    set_slot(2, 0, 0, 0, 0, 0);
    set_slot(3, 0, 0, 0, 0, 0);
    push_group();
    repeat (4) begin
      check("R7 out_valid low while short", int'(out_valid), 0);
      check("R7 in_ready low while short", int'(in_ready), 0);
      @(negedge clk);
    end
    rel_valid[3] = 1'b1;
    rel_preg[3*PW +: PW] = 9'(3 * 128 + 8);
    fmem[3][ftail[3]] = 8;
    ftail[3]++;
    @(negedge clk);
    rel_valid[3] = 1'b0;
    model_group();
    receive("R7 R8 resume");
  endtask

  initial begin
    model_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mixed();
    t_dep();
    t_same();
    t_backpressure();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL R10 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule